// File: doc/BRIEF.md
# Word-Buffered Monochrome Pixel Serializer

This block turns 32-bit words, written into it by a DMA engine, into a serial monochrome pixel stream of one bit per dot clock. The words are held in a small first-in first-out buffer. A shift register unloads them most-significant bit first, and back-to-back words follow each other with no gap. When the buffer holds nothing more to send, the pixel line falls to zero (black) on the dot clock right after the last bit. It does not stall, and it does not repeat old data.

Refill works on a low-water mark. Software sets a threshold in the control word. While the block is enabled and the fill level is at or below that threshold, a request line stays high to ask the DMA engine for more words. The current fill level is always visible on an output. A write that arrives when the buffer is full is dropped and sets a sticky overflow flag. When software clears the enable bit, the block flushes all buffered data, darkens the output and clears the flag.

Top module: `pixel_serializer`

## Requirements
- R1: After reset the fill level is 0, and the pixel output, the refill request and the overflow flag are all 0. The block starts disabled.
- R2: The buffer holds up to 8 words. `fillLevel` reports how many words are buffered and not yet moved into the shifter. A write accepted at a clock edge raises the level after that edge.
- R3: The block must be enabled. A word written into the empty, idle block moves into the shifter at the next edge. Its bit 31 appears on `pixelOut` after that edge, and bits 30 down to 0 follow, one per clock.
- R4: When another word is buffered, it starts on the clock right after bit 0 of the current word, so the stream has no gap. Words leave in the order they were written.
- R5: When the buffer is empty after the last bit of a word, `pixelOut` is 0 from the next clock on.
- R6: The control word has the enable in bit 1 and a 4-bit threshold in bits 19:16. `refillReq` is 1 exactly when the block is enabled and the fill level is less than or equal to the threshold. A full buffer drained with threshold 2 first requests at level 2.
- R7: A write while the buffer is full and no word leaves in that cycle is discarded, and `overflowFlag` is set. The flag stays set until a flush.
- R8: A control write with bit 1 at 0 flushes the block. After that edge the fill level is 0, and `pixelOut`, `refillReq` and `overflowFlag` are all 0.
- R9: While the block is disabled, word writes are ignored. The fill level stays 0, and enabling the block afterwards releases no pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Word write strobe from the DMA engine |
| wrData | input | 32 | Word to buffer |
| ctrlWrite | input | 1 | Control word write strobe |
| ctrlData | input | 32 | Control word: bit 1 enable, bits 19:16 threshold |
| refillReq | output | 1 | Refill request to the DMA engine |
| fillLevel | output | 4 | Number of buffered words |
| overflowFlag | output | 1 | Sticky flag for a dropped write |
| pixelOut | output | 1 | Serial pixel, 1 = lit |

## Verification
The assertions take for granted that every input is driven to a known level after reset and is stable around the rising edge. They also assume a control write is a single-cycle strobe whose enable bit alone decides whether a flush happens. The DMA side may write at any time, including into a full buffer or while the block is disabled, so the overflow and ignore checks depend on no rule about the writer. The stimulus changes every input only on the falling edge, raises each strobe for whole cycles, and always writes the control word with defined threshold bits.

// File: rtl/pixser_pkg.sv
`timescale 1ns/1ps
package pixser_pkg;

  // Strobes sent from the control half to the datapath half each cycle
  typedef struct packed {
    logic push;   // store wrData at the write pointer
    logic load;   // move the head word into the shifter
    logic shift;  // advance the shifter by one bit
    logic flush;  // clear pointers and shifter
  } pxStrobe_t;

endpackage

// File: rtl/pixser_datapath.sv
`timescale 1ns/1ps
module pixser_datapath
  import pixser_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pxStrobe_t         strb,
  input  logic [WORD_W-1:0] wrData,
  output logic              shiftMsb
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [WORD_W-1:0] shiftReg;

  function automatic logic [PTR_W-1:0] nextSlot(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // Word storage, no reset needed: the pointers decide what is valid
  always_ff @(posedge clk) begin
    if (strb.push) begin
      store[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextSlot(wrPtr);
      if (strb.load) rdPtr <= nextSlot(rdPtr);
    end
  end

  // Shifter: the most significant bit is the pixel on view
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.flush) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= store[rdPtr];
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign shiftMsb = shiftReg[WORD_W-1];

endmodule

// File: rtl/pixser_ctrl.sv
`timescale 1ns/1ps
module pixser_ctrl
  import pixser_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  parameter int THR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic                       ctrlWrite,
  input  logic                       ctrlEnBit,
  input  logic [THR_W-1:0]           ctrlThr,
  input  logic                       shiftMsb,
  output pxStrobe_t                  strb,
  output logic                       refillReq,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                       overflowFlag,
  output logic                       pixelOut,
  output logic                       enState,
  output logic [THR_W-1:0]           thrState
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [BIT_W-1:0] WORD_BITS = BIT_W'(WORD_W);
  localparam logic [BIT_W-1:0] ONE_BIT   = BIT_W'(1);

  logic             enReg;
  logic [THR_W-1:0] thrReg;
  logic [CNT_W-1:0] count;
  logic             active;
  logic [BIT_W-1:0] bitCnt;
  logic             ovfReg;

  logic flushNow, fifoEmpty, fifoFull, lastBit, wantWord;
  logic doLoad, doShift, doPush, dropWrite;

  always_comb begin
    flushNow  = ctrlWrite && !ctrlEnBit;
    fifoEmpty = (count == '0);
    fifoFull  = (count == FULL_CNT);
    lastBit   = active && (bitCnt == ONE_BIT);
    wantWord  = enReg && !flushNow && (!active || lastBit);
    doLoad    = wantWord && !fifoEmpty;
    doShift   = enReg && !flushNow && active && !lastBit;
    doPush    = wrValid && enReg && !flushNow && (!fifoFull || doLoad);
    dropWrite = wrValid && enReg && !flushNow && fifoFull && !doLoad;
  end

  always_comb begin
    strb.push  = doPush;
    strb.load  = doLoad;
    strb.shift = doShift;
    strb.flush = flushNow;
  end

  // Control word fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      thrReg <= '0;
    end else if (ctrlWrite) begin
      enReg  <= ctrlEnBit;
      thrReg <= ctrlThr;
    end
  end

  // Buffer occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (flushNow) begin
      count <= '0;
    end else begin
      unique case ({doPush, doLoad})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Shifter occupancy: bits left in the current word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (flushNow) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (doLoad) begin
      active <= 1'b1;
      bitCnt <= WORD_BITS;
    end else if (doShift) begin
      bitCnt <= bitCnt - 1'b1;
    end else if (lastBit) begin
      active <= 1'b0;
      bitCnt <= '0;
    end
  end

  // Sticky record of a discarded write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfReg <= 1'b0;
    end else if (flushNow) begin
      ovfReg <= 1'b0;
    end else if (dropWrite) begin
      ovfReg <= 1'b1;
    end
  end

  assign refillReq    = enReg && (32'(count) <= 32'(thrReg));
  assign fillLevel    = count;
  assign overflowFlag = ovfReg;
  assign pixelOut     = enReg && active && shiftMsb;
  assign enState      = enReg;
  assign thrState     = thrReg;

endmodule

// File: rtl/pixel_serializer.sv
`timescale 1ns/1ps
module pixel_serializer
  import pixser_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int WORD_W  = 32,
  parameter int CTRL_W  = 32,
  parameter int EN_BIT  = 1,
  parameter int THR_LSB = 16,
  parameter int THR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic [WORD_W-1:0]          wrData,
  input  logic                       ctrlWrite,
  input  logic [CTRL_W-1:0]          ctrlData,
  output logic                       refillReq,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                       overflowFlag,
  output logic                       pixelOut
);

  pxStrobe_t        ctrlStrb;
  logic             shiftMsb;
  logic             enState;
  logic [THR_W-1:0] thrState;

  pixser_ctrl #(
    .DEPTH (DEPTH),
    .WORD_W(WORD_W),
    .THR_W (THR_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .ctrlWrite   (ctrlWrite),
    .ctrlEnBit   (ctrlData[EN_BIT]),
    .ctrlThr     (ctrlData[THR_LSB +: THR_W]),
    .shiftMsb    (shiftMsb),
    .strb        (ctrlStrb),
    .refillReq   (refillReq),
    .fillLevel   (fillLevel),
    .overflowFlag(overflowFlag),
    .pixelOut    (pixelOut),
    .enState     (enState),
    .thrState    (thrState)
  );

  pixser_datapath #(
    .DEPTH (DEPTH),
    .WORD_W(WORD_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (ctrlStrb),
    .wrData  (wrData),
    .shiftMsb(shiftMsb)
  );

endmodule

// File: rtl/pixel_serializer_chk.sv
`timescale 1ns/1ps
module pixel_serializer_chk #(
  parameter int DEPTH  = 8,
  parameter int CTRL_W = 32,
  parameter int EN_BIT = 1,
  parameter int THR_W  = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       ctrlWrite,
  input logic [CTRL_W-1:0]          ctrlData,
  input logic                       wrValid,
  input logic                       refillReq,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel,
  input logic                       overflowFlag,
  input logic                       pixelOut,
  input logic                       enState,
  input logic [THR_W-1:0]           thrState
);

  logic flushReq;
  assign flushReq = ctrlWrite && !ctrlData[EN_BIT];

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillLevel) <= DEPTH);

  assert_level_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !flushReq |=> (int'(fillLevel) <= int'($past(fillLevel)) + 1) &&
                  (int'(fillLevel) + 1 >= int'($past(fillLevel))));

  assert_no_growth_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> int'(fillLevel) <= int'($past(fillLevel)));

  assert_req_above_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enState && int'(fillLevel) > int'(thrState)) |-> !refillReq);

  assert_req_below_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enState && int'(fillLevel) <= int'(thrState)) |-> refillReq);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !flushReq) |=> overflowFlag);

  assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> ($past(wrValid) && int'($past(fillLevel)) == DEPTH));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (fillLevel == '0) && !pixelOut && !overflowFlag && !refillReq);

  assert_dark_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enState |-> (!pixelOut && fillLevel == '0 && !refillReq));

endmodule

bind pixel_serializer pixel_serializer_chk #(
  .DEPTH (DEPTH),
  .CTRL_W(CTRL_W),
  .EN_BIT(EN_BIT),
  .THR_W (THR_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWrite   (ctrlWrite),
  .ctrlData    (ctrlData),
  .wrValid     (wrValid),
  .refillReq   (refillReq),
  .fillLevel   (fillLevel),
  .overflowFlag(overflowFlag),
  .pixelOut    (pixelOut),
  .enState     (enState),
  .thrState    (thrState)
);

// File: tb/pixel_serializer_tb_top.sv
`timescale 1ns/1ps
module pixel_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        ctrlWrite = 1'b0;
  logic [31:0] ctrlData = '0;
  logic        refillReq;
  logic [3:0]  fillLevel;
  logic        overflowFlag;
  logic        pixelOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_serializer dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .wrData      (wrData),
    .ctrlWrite   (ctrlWrite),
    .ctrlData    (ctrlData),
    .refillReq   (refillReq),
    .fillLevel   (fillLevel),
    .overflowFlag(overflowFlag),
    .pixelOut    (pixelOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Control word: bit 1 enable, bits 19:16 threshold, extra bits as given
  task automatic setCtrl(input bit en, input int thr, input logic [31:0] extra);
    @(negedge clk);
    ctrlWrite = 1'b1;
    ctrlData  = extra | (32'(en) << 1) | ((32'(thr) & 32'hF) << 16);
    @(negedge clk);
    ctrlWrite = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "level", 32'(fillLevel), 0);
    check("R1", "pixel", 32'(pixelOut), 0);
    check("R1", "req", 32'(refillReq), 0);
    check("R1", "ovf", 32'(overflowFlag), 0);
  endtask

  task automatic testSingleWord();
    logic [31:0] w;
    w = 32'hA5C3_0F81;
    setCtrl(1'b1, 0, 32'h0);
    check("R6", "req empty thr0", 32'(refillReq), 1);
    @(negedge clk); wrValid = 1'b1; wrData = w;
    @(negedge clk); wrValid = 1'b0;
    check("R2", "level one word", 32'(fillLevel), 1);
    check("R6", "req level1 thr0", 32'(refillReq), 0);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      check("R3", $sformatf("bit %0d", i), 32'(pixelOut), 32'(w[i]));
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5", "dark after last bit", 32'(pixelOut), 0);
    end
    check("R6", "req drained thr0", 32'(refillReq), 1);
  endtask

  task automatic testBackToBack();
    logic [63:0] pair;
    pair = 64'h8000_0001_F0F0_3C3D;
    @(negedge clk); wrValid = 1'b1; wrData = pair[63:32];
    @(negedge clk); wrData = pair[31:0];
    @(negedge clk); wrValid = 1'b0;
    for (int i = 63; i >= 0; i--) begin
      if (i != 63) @(negedge clk);
      check("R4", $sformatf("stream bit %0d", i), 32'(pixelOut), 32'(pair[i]));
    end
    @(negedge clk);
    check("R5", "dark after pair", 32'(pixelOut), 0);
  endtask

  task automatic testThreshold();
    int prevLevel;
    bit seen;
    setCtrl(1'b1, 2, 32'h0);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); wrValid = 1'b1; wrData = 32'h1111_0000 + 32'(n);
    end
    @(negedge clk); wrValid = 1'b0;
    check("R2", "level full", 32'(fillLevel), 8);
    check("R7", "ovf after drop", 32'(overflowFlag), 1);
    check("R6", "req when full", 32'(refillReq), 0);
    prevLevel = 8;
    seen = 1'b0;
    for (int c = 0; c < 400 && !seen; c++) begin
      @(negedge clk);
      if (refillReq) begin
        seen = 1'b1;
        check("R6", "level at first request", 32'(fillLevel), 2);
        check("R6", "level before request", 32'(prevLevel), 3);
      end
      prevLevel = int'(fillLevel);
    end
    check("R6", "request seen", 32'(seen), 1);
    check("R7", "ovf still set", 32'(overflowFlag), 1);
  endtask

  task automatic testFlush();
    setCtrl(1'b0, 2, 32'h0);
    check("R8", "level", 32'(fillLevel), 0);
    check("R8", "pixel", 32'(pixelOut), 0);
    check("R8", "ovf", 32'(overflowFlag), 0);
    check("R8", "req", 32'(refillReq), 0);
  endtask

  task automatic testDisabledWrites();
    setCtrl(1'b0, 2, 32'h0000_0001);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); wrValid = 1'b1; wrData = 32'hFFFF_FFFF;
    end
    @(negedge clk); wrValid = 1'b0;
    check("R9", "level while off", 32'(fillLevel), 0);
    check("R9", "pixel while off", 32'(pixelOut), 0);
    setCtrl(1'b1, 0, 32'h0);
    check("R9", "level after enable", 32'(fillLevel), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9", "no stale pixel", 32'(pixelOut), 0);
    end
    check("R6", "req empty after enable", 32'(refillReq), 1);
  endtask

  task automatic testHighThreshold();
    setCtrl(1'b1, 15, 32'h0);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); wrValid = 1'b1; wrData = 32'h0;
    end
    @(negedge clk); wrValid = 1'b0;
    check("R6", "req full thr15", 32'(refillReq), 1);
    check("R2", "level full thr15", 32'(fillLevel), 8);
    setCtrl(1'b0, 0, 32'h0);
    check("R8", "level after second flush", 32'(fillLevel), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleWord();
    testBackToBack();
    testThreshold();
    testFlush();
    testDisabledWrites();
    testHighThreshold();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule